// File: doc/BRIEF.md
# Event Routing Channel

One channel of a peripheral event router. A 7-bit selector picks one generator line out of a bus of up to 127 sources. The channel carries that line to its output along one of three paths. The synchronous path samples the line once in the channel clock domain. The resynchronized path runs it through a two-stage synchronizer. The asynchronous path passes the level straight through. On the two clocked paths, an edge detector turns level changes into single-cycle event pulses of the chosen polarity.

All settings sit in one 32-bit control word that is loaded by a single write strobe. The channel also drives a clock-request output. With on-demand clocking, the request is raised only while an event travels through the channel. Otherwise it is held whenever the channel is configured. A run-in-standby bit decides whether the channel keeps working while the system standby input is high.

Top module: `evt_chan_top`

## Requirements
- R1: After reset the control word reads 0x00008000, and `evt_o` and `clk_req_o` are low. The sample pipeline also resets low.
- R2: While `cfg_we_i` is high at a clock edge, the control word loads `cfg_wdata_i & 0x0000CF7F`. Bits 31:16, 13:12 and 7 read zero. With no write, the word holds its value.
- R3: Bits 6:0 select the generator index into `gen_i`. Index 0 and indices above 0x58 select nothing: `evt_o` and `clk_req_o` stay low.
- R4: Path field bits 9:8 = 0 (synchronous). A change of the selected line is sampled once. A matching edge makes `evt_o` high for exactly the one cycle after the first clock edge that samples the change.
- R5: Path = 1 (resynchronized). The selected line passes two flops. A matching edge makes `evt_o` high for exactly the one cycle after the second clock edge that samples the change.
- R6: Path = 2 (asynchronous). `evt_o` follows the selected line with no clock stage and no edge detection, whatever the edge field holds.
- R7: Path = 3 (reserved). `evt_o` and `clk_req_o` are low.
- R8: Edge field bits 11:10 selects the edge on the clocked paths: 0 gives no event, 1 gives rising edges only, 2 gives falling edges only, 3 gives both edges.
- R9: On-demand bit 15 = 1. `clk_req_o` rises without a clock edge as soon as a matching edge is on the selected line. It stays high while that edge moves through the pipeline and through the pulse cycle, then for one more cycle, and then drops. On the asynchronous path it follows the selected level.
- R10: On-demand bit 15 = 0. `clk_req_o` is high whenever the generator and path are valid and the channel is not stopped by standby.
- R11: Run-in-standby bit 14 = 0 with `standby_i` high forces `evt_o` and `clk_req_o` low. With bit 14 = 1, standby has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_q_o | output | 32 | Current control word |
| gen_i | input | 128 | Generator lines, index 0 unused |
| standby_i | input | 1 | System standby indication |
| evt_o | output | 1 | Channel event output |
| clk_req_o | output | 1 | Channel clock request |

## Verification
Random generator traffic is run with frequent toggles on the selected line. Random control words are mixed in, covering every path and edge code and invalid generator indices. This separates one-stage from two-stage latency and rising from falling detection. It also separates pass-through from pulsed output. Directed sequences hold the selected line steady and then flip it once. This pins the exact cycles of the pulse and of the clock request's rise and fall. Writing a word of all ones shows the unused bits reading zero and the reserved path muting the channel. Toggling standby with both settings of the run-in-standby bit shows when the channel is stopped and when it keeps running.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    logic       on_demand;
    logic       run_stby;
    edge_e      edge_sel;
    path_e      path;
    logic [6:0] gen_sel;
  } cfg_t;

  localparam logic [31:0] CFG_RESET = 32'h0000_8000;
  localparam logic [31:0] CFG_MASK  = 32'h0000_CF7F;

  function automatic logic edge_hit(edge_e e, logic now_v, logic old_v);
    return (e[0] & now_v & ~old_v) | (e[1] & ~now_v & old_v);
  endfunction

endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
  import evt_chan_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] word_o,
  output cfg_t        cfg_o
);
  logic [31:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= CFG_RESET;
    else if (we_i) word_q <= wdata_i & CFG_MASK;
  end

  assign word_o = word_q;

  always_comb begin
    cfg_o.on_demand = word_q[15];
    cfg_o.run_stby  = word_q[14];
    cfg_o.edge_sel  = edge_e'(word_q[11:10]);
    cfg_o.path      = path_e'(word_q[9:8]);
    cfg_o.gen_sel   = word_q[6:0];
  end
endmodule

// File: rtl/evt_chan_mux.sv
module evt_chan_mux #(
  parameter int unsigned GEN_W    = 7,
  parameter int unsigned GEN_LAST = 88,
  localparam int unsigned N_GEN   = 1 << GEN_W
) (
  input  logic [N_GEN-1:0] gen_i,
  input  logic [GEN_W-1:0] sel_i,
  output logic             valid_o,
  output logic             sig_o
);
  assign valid_o = (sel_i != '0) && (int'(sel_i) <= int'(GEN_LAST));
  assign sig_o   = valid_o & gen_i[sel_i];
endmodule

// File: rtl/evt_chan_pipe.sv
module evt_chan_pipe
  import evt_chan_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  input  logic  active_i,
  input  path_e path_i,
  input  edge_e edge_i,
  input  logic  on_demand_i,
  output logic  evt_o,
  output logic  req_o
);
  logic [DEPTH-1:0] st_q;
  logic             hold_q;
  logic             clocked, resync, cur, prv, pulse, early, mid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= {st_q[DEPTH-2:0], sig_i};
      hold_q <= active_i & clocked & pulse;
    end
  end

  assign clocked = (path_i == PATH_SYNC) || (path_i == PATH_RESYNC);
  assign resync  = (path_i == PATH_RESYNC);
  assign cur     = resync ? st_q[1] : st_q[0];
  assign prv     = resync ? st_q[2] : st_q[1];
  assign pulse   = edge_hit(edge_i, cur, prv);
  // edge still in flight ahead of the detector
  assign early   = edge_hit(edge_i, sig_i, st_q[0]);
  assign mid     = resync & edge_hit(edge_i, st_q[0], st_q[1]);

  always_comb begin
    evt_o = 1'b0;
    req_o = 1'b0;
    if (active_i) begin
      if (path_i == PATH_ASYNC) begin
        evt_o = sig_i;
        req_o = ~on_demand_i | sig_i;
      end else begin
        evt_o = pulse;
        req_o = ~on_demand_i | early | mid | pulse | hold_q;
      end
    end
  end
endmodule

// File: rtl/evt_chan_top.sv
module evt_chan_top
  import evt_chan_pkg::*;
#(
  parameter int unsigned GEN_W    = 7,
  parameter int unsigned GEN_LAST = 88,
  localparam int unsigned N_GEN   = 1 << GEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_q_o,
  input  logic [N_GEN-1:0] gen_i,
  input  logic             standby_i,
  output logic             evt_o,
  output logic             clk_req_o
);
  cfg_t cfg;
  logic gen_valid, gen_sig, active;

  evt_chan_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .word_o  (cfg_q_o),
    .cfg_o   (cfg)
  );

  evt_chan_mux #(.GEN_W(GEN_W), .GEN_LAST(GEN_LAST)) u_mux (
    .gen_i   (gen_i),
    .sel_i   (cfg.gen_sel[GEN_W-1:0]),
    .valid_o (gen_valid),
    .sig_o   (gen_sig)
  );

  assign active = gen_valid && (cfg.path != PATH_RSVD) &&
                  !(standby_i && !cfg.run_stby);

  evt_chan_pipe #(.DEPTH(3)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sig_i       (gen_sig),
    .active_i    (active),
    .path_i      (cfg.path),
    .edge_i      (cfg.edge_sel),
    .on_demand_i (cfg.on_demand),
    .evt_o       (evt_o),
    .req_o       (clk_req_o)
  );
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
  parameter int unsigned GEN_W    = 7,
  parameter int unsigned GEN_LAST = 88,
  localparam int unsigned N_GEN   = 1 << GEN_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [31:0]      cfg_wdata_i,
  input logic [31:0]      cfg_q_o,
  input logic [N_GEN-1:0] gen_i,
  input logic             standby_i,
  input logic             evt_o,
  input logic             clk_req_o
);
  logic       gen_ok, stopped;
  logic [1:0] path, edg;
  assign path    = cfg_q_o[9:8];
  assign edg     = cfg_q_o[11:10];
  assign gen_ok  = (cfg_q_o[6:0] != 7'd0) && (int'(cfg_q_o[6:0]) <= int'(GEN_LAST));
  assign stopped = standby_i && !cfg_q_o[14];

  always @(posedge clk_i)
    if (!rst_ni) p_reset_word_r1: assert (cfg_q_o == 32'h0000_8000);

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q_o == ($past(cfg_wdata_i) & 32'h0000_CF7F));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q_o));
  p_bad_gen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_ok |-> !evt_o && !clk_req_o);
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && path < 2'd2 && edg != 2'd3 && !cfg_we_i) |=> !evt_o);
  p_async_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path == 2'd2 && gen_ok && !stopped) |-> evt_o == gen_i[cfg_q_o[GEN_W-1:0]]);
  p_rsvd_path_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path == 2'd3 |-> !evt_o && !clk_req_o);
  p_no_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path < 2'd2 && edg == 2'd0) |-> !evt_o);
  p_req_covers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> clk_req_o);
  p_always_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q_o[15] && gen_ok && path != 2'd3 && !stopped) |-> clk_req_o);
  p_standby_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped |-> !evt_o && !clk_req_o);
endmodule

bind evt_chan_top evt_chan_chk #(.GEN_W(GEN_W), .GEN_LAST(GEN_LAST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_q_o     (cfg_q_o),
  .gen_i       (gen_i),
  .standby_i   (standby_i),
  .evt_o       (evt_o),
  .clk_req_o   (clk_req_o)
);

// File: tb/tb_evt_chan_top.sv
`timescale 1ns/1ps
module tb_evt_chan_top;
  localparam int GEN_LAST = 88;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         cfg_we_i = 1'b0;
  logic [31:0]  cfg_wdata_i = '0;
  logic [31:0]  cfg_q_o;
  logic [127:0] gen_i = '0;
  logic         standby_i = 1'b0;
  logic         evt_o, clk_req_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  evt_chan_top dut (.*);

  // reference state
  logic [31:0] m_cfg;
  logic m0, m1, m2, mh;

  function automatic logic hit(logic [1:0] e, logic a, logic b);
    return (e[0] && a && !b) || (e[1] && !a && b);
  endfunction

  function automatic logic gv(logic [31:0] c);
    return c[6:0] != 0 && int'(c[6:0]) <= GEN_LAST;
  endfunction

  function automatic logic msig(logic [31:0] c, logic [127:0] g);
    return gv(c) && g[c[6:0]];
  endfunction

  function automatic logic act(logic [31:0] c, logic s);
    return gv(c) && c[9:8] != 2'd3 && !(s && !c[14]);
  endfunction

  function automatic logic mpulse(logic [31:0] c);
    return (c[9:8] == 2'd1) ? hit(c[11:10], m1, m2) : hit(c[11:10], m0, m1);
  endfunction

  function automatic logic exp_evt(logic [31:0] c, logic [127:0] g, logic s);
    if (!act(c, s)) return 1'b0;
    if (c[9:8] == 2'd2) return msig(c, g);
    return mpulse(c);
  endfunction

  function automatic logic exp_req(logic [31:0] c, logic [127:0] g, logic s);
    if (!act(c, s)) return 1'b0;
    if (!c[15]) return 1'b1;
    if (c[9:8] == 2'd2) return msig(c, g);
    return mpulse(c) || mh || hit(c[11:10], msig(c, g), m0) ||
           (c[9:8] == 2'd1 && hit(c[11:10], m0, m1));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg <= 32'h0000_8000;
      {m0, m1, m2, mh} <= '0;
    end else begin
      if (cfg_we_i) m_cfg <= cfg_wdata_i & 32'h0000_CF7F;
      m0 <= msig(m_cfg, gen_i);
      m1 <= m0;
      m2 <= m1;
      mh <= act(m_cfg, standby_i) && m_cfg[9:8] < 2'd2 && mpulse(m_cfg);
    end
  end

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic string evt_tag(logic [31:0] c, logic s);
    if (!gv(c)) return "R3";
    if (c[9:8] == 2'd3) return "R7";
    if (s && !c[14]) return "R11";
    case (c[9:8])
      2'd0: return "R4";
      2'd1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model_cmp();
    chk({evt_tag(m_cfg, standby_i), " evt"}, 32'(evt_o), 32'(exp_evt(m_cfg, gen_i, standby_i)));
    chk(m_cfg[15] ? "R9 req" : "R10 req", 32'(clk_req_o), 32'(exp_req(m_cfg, gen_i, standby_i)));
  endtask

  // apply inputs after a falling edge, then compare with the reference
  task automatic step(logic we, logic [31:0] wd, logic [127:0] g, logic s);
    @(negedge clk_i);
    cfg_we_i = we; cfg_wdata_i = wd; gen_i = g; standby_i = s;
    #2;
    model_cmp();
  endtask

  task automatic wr(logic [31:0] wd);
    step(1'b1, wd, gen_i, standby_i);
    step(1'b0, '0, gen_i, standby_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] g;
    void'($urandom(32'd1234));
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 cfg reset", cfg_q_o, 32'h0000_8000);
    chk("R1 evt reset", 32'(evt_o), 32'd0);
    chk("R1 req reset", 32'(clk_req_o), 32'd0);
    rst_ni = 1'b1;

    // R2 masking, R7 reserved path with reserved generator
    wr(32'hFFFF_FFFF);
    chk("R2 masked word", cfg_q_o, 32'h0000_CF7F);
    step(1'b0, '0, '1, 1'b0);
    chk("R7 evt low", 32'(evt_o), 32'd0);
    chk("R7 req low", 32'(clk_req_o), 32'd0);

    // R4 / R9: sync rising on generator 5
    gen_i = '0;
    wr(32'h0000_8405);
    repeat (3) step(1'b0, '0, '0, 1'b0);
    step(1'b0, '0, 128'h20, 1'b0);
    chk("R9 early req", 32'(clk_req_o), 32'd1);
    chk("R4 no evt yet", 32'(evt_o), 32'd0);
    step(1'b0, '0, 128'h20, 1'b0);
    chk("R4 pulse", 32'(evt_o), 32'd1);
    step(1'b0, '0, 128'h20, 1'b0);
    chk("R4 pulse ends", 32'(evt_o), 32'd0);
    chk("R9 hold req", 32'(clk_req_o), 32'd1);
    step(1'b0, '0, 128'h20, 1'b0);
    chk("R9 req drops", 32'(clk_req_o), 32'd0);
    step(1'b0, '0, '0, 1'b0);
    chk("R8 rising ignores fall", 32'(clk_req_o), 32'd0);
    step(1'b0, '0, '0, 1'b0);
    chk("R8 rising ignores fall", 32'(evt_o), 32'd0);

    // R5 / R8: resync falling on generator 88
    wr(32'h0000_8958);
    step(1'b0, '0, {39'd0, 1'b1, 88'd0}, 1'b0);
    repeat (3) step(1'b0, '0, gen_i, 1'b0);
    step(1'b0, '0, '0, 1'b0);
    step(1'b0, '0, '0, 1'b0);
    chk("R5 no evt after one edge", 32'(evt_o), 32'd0);
    step(1'b0, '0, '0, 1'b0);
    chk("R5 R8 falling pulse", 32'(evt_o), 32'd1);

    // R11 standby
    wr(32'h0000_0201);
    step(1'b0, '0, 128'h2, 1'b1);
    chk("R11 stopped", 32'(evt_o), 32'd0);
    wr(32'h0000_4201);
    step(1'b0, '0, 128'h2, 1'b1);
    chk("R11 runs in standby", 32'(evt_o), 32'd1);
    chk("R10 always req", 32'(clk_req_o), 32'd1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      logic we;
      g = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 2) != 0) g[m_cfg[6:0]] = gen_i[m_cfg[6:0]];
      we = ($urandom_range(0, 15) == 0);
      wd = $urandom;
      case ($urandom_range(0, 7))
        0: wd[6:0] = 7'd0;
        1: wd[6:0] = 7'($urandom_range(GEN_LAST + 1, 127));
        default: wd[6:0] = 7'($urandom_range(1, GEN_LAST));
      endcase
      step(we, wd, g, ($urandom_range(0, 7) == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule